// File: doc/BRIEF.md
# Programmable Cross-Trigger Fabric

This block connects trigger sources to trigger sinks across several interface units through a shared channel matrix. Each interface unit takes eight trigger inputs and drives eight trigger outputs. It also drives four channels into the matrix and receives four channels back from it. The matrix ORs the channel lines of all attached units together with no registers on the path. Any channel event raised by one unit is therefore seen by every unit on the same channel in the same cycle.

Two sets of enable masks set the routing in each unit. The first set chooses which inputs drive each channel. The second set chooses which outputs each channel drives. With these masks, one input can reach one output or many outputs, and several inputs can merge onto one output. This works inside one unit and from one unit to another.

A per-unit enable gates all channel-to-output routing for that unit. An apply strobe lets software pulse channels directly. A rising edge on an input counts as one event. An output that fires stays high until the attached logic acknowledges it.

The configuration port uses a valid/ready handshake. `cfg_ready` is held high, so a write is accepted on every cycle where `cfg_valid` is high, and the port never applies back-pressure. The trigger pins use a request/acknowledge handshake rather than valid/ready.

Top module: `xtrig_fabric`

## Requirements
- R1: After reset, all of the following are zero: every trigger output, every input acknowledge, every routing mask and every unit enable. `cfg_ready` is 1.
- R2: A write is taken when `cfg_valid` is 1. `cfg_unit` selects the unit. `cfg_addr` selects the target: 0 is the control register, where `cfg_data` bit 0 is the unit enable. Addresses 4+c hold the input mask of channel c, where bit i selects input i. Addresses 8+c hold the output mask of channel c, where bit o selects output o. Address 12 is the apply strobe. A written value takes effect from the next cycle.
- R3: A rising edge on a trigger input produces exactly one channel event. An input held high for many cycles produces no further events.
- R4: Each `trig_in_ack` bit equals the matching `trig_in` bit one clock later.
- R5: A trigger output rises two clock edges after a rising edge on an input when any channel is enabled both from that input and to that output. This covers one-to-one, one-to-many and many-to-one routing.
- R6: A channel event from one unit reaches the outputs of every other unit that is enabled from that channel, with the same latency as inside one unit.
- R7: A fired output stays high until its acknowledge is sampled high, and it is low on the following cycle. If a new event arrives in the same cycle as the acknowledge, the new event wins and the output stays high.
- R8: When a unit's enable is 0, none of that unit's outputs rise. That unit's inputs still drive channels that reach the other units.
- R9: Writing mask m to address 12 of a unit pulses the channels in m for one cycle. The outputs enabled from those channels rise on the edge after the write.
- R10: Writes to addresses 1 to 3 and 13 to 15 change nothing: no routing changes and no output fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready (always 1) |
| cfg_unit | input | 2 | Target interface unit |
| cfg_addr | input | 4 | Register address within the unit |
| cfg_data | input | 8 | Write data |
| trig_in | input | 32 | Trigger inputs, unit u owns bits 8u+7 down to 8u |
| trig_in_ack | output | 32 | Input acknowledge, one per input |
| trig_out | output | 32 | Trigger outputs, same bit layout as the inputs |
| trig_out_ack | input | 32 | Acknowledge from the logic that takes each output |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a fresh event on the same output. A second case is an input that stays high across an acknowledge, where it must not fire again. Directed sequences hold `trig_out_ack` high while an input rises, and hold an input high through several acknowledge cycles. Random trials then mix random mask writes, including writes to unused addresses, with sparse multi-unit input bursts. These trials exercise one-to-many and many-to-one paths across the matrix, and a bench model of the masks predicts every output bit.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int unsigned TRIG_W = 8;
  localparam int unsigned CHAN_W = 4;
  localparam int unsigned UNIT_N = 4;
  localparam int unsigned ADDR_W = 4;

  // Register address layout inside one unit
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_IN_BASE  = 4;
  localparam int unsigned A_OUT_BASE = 8;
  localparam int unsigned A_APPLY    = 12;
endpackage

// File: rtl/xtrig_edge.sv
module xtrig_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise_pulse,
  output logic [W-1:0] sig_ack
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= '0;
      rise_pulse <= '0;
      sig_ack    <= '0;
    end else begin
      prev_q     <= sig_in;
      rise_pulse <= sig_in & ~prev_q;
      sig_ack    <= sig_in;
    end
  end

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse != '0) |=> ((rise_pulse & $past(rise_pulse)) == '0)); // R3
endmodule

// File: rtl/xtrig_outstage.sv
module xtrig_outstage #(
  parameter int unsigned TRIG_W = 8,
  parameter int unsigned CHAN_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           route_en,
  input  logic [CHAN_W-1:0]              chan_in,
  input  logic [CHAN_W-1:0][TRIG_W-1:0]  out_mask,
  input  logic [TRIG_W-1:0]              trig_ack,
  output logic [TRIG_W-1:0]              trig_out
);
  logic [TRIG_W-1:0] fire;

  for (genvar o = 0; o < TRIG_W; o++) begin : g_out
    logic [CHAN_W-1:0] hits;
    for (genvar c = 0; c < CHAN_W; c++) begin : g_ch
      assign hits[c] = chan_in[c] & out_mask[c][o];
    end
    assign fire[o] = route_en & (|hits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_out <= '0;
    else        trig_out <= (trig_out & ~trig_ack) | fire;
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trig_out & $past(trig_out & ~trig_ack)) == $past(trig_out & ~trig_ack))); // R7
  AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en |=> ((trig_out & ~$past(trig_out)) == '0)); // R8
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
  import xtrig_pkg::*;
#(
  parameter int unsigned UNIT_ID = 0,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned TW      = TRIG_W,
  parameter int unsigned CW      = CHAN_W,
  parameter int unsigned AW      = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [SEL_W-1:0] cfg_unit,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_data,
  input  logic [TW-1:0] trig_in,
  output logic [TW-1:0] trig_in_ack,
  output logic [TW-1:0] trig_out,
  input  logic [TW-1:0] trig_out_ack,
  output logic [CW-1:0] chan_to_mx,
  input  logic [CW-1:0] chan_from_mx
);
  logic                   wr_hit;
  logic                   en_q;
  logic [CW-1:0][TW-1:0]  in_mask_q;
  logic [CW-1:0][TW-1:0]  out_mask_q;
  logic [CW-1:0]          apply_q;
  logic [TW-1:0]          rise;

  assign wr_hit = cfg_valid && (cfg_unit == SEL_W'(UNIT_ID));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      in_mask_q  <= '0;
      out_mask_q <= '0;
      apply_q    <= '0;
    end else begin
      apply_q <= '0;
      if (wr_hit) begin
        if (cfg_addr == AW'(A_CTRL))  en_q    <= cfg_data[0];
        if (cfg_addr == AW'(A_APPLY)) apply_q <= cfg_data[CW-1:0];
        for (int c = 0; c < CW; c++) begin
          if (cfg_addr == AW'(A_IN_BASE + c))  in_mask_q[c]  <= cfg_data;
          if (cfg_addr == AW'(A_OUT_BASE + c)) out_mask_q[c] <= cfg_data;
        end
      end
    end
  end

  xtrig_edge #(.W(TW)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (trig_in),
    .rise_pulse(rise),
    .sig_ack   (trig_in_ack)
  );

  for (genvar c = 0; c < CW; c++) begin : g_chan
    assign chan_to_mx[c] = (|(rise & in_mask_q[c])) | apply_q[c];
  end

  xtrig_outstage #(.TRIG_W(TW), .CHAN_W(CW)) outs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .route_en(en_q),
    .chan_in (chan_from_mx),
    .out_mask(out_mask_q),
    .trig_ack(trig_out_ack),
    .trig_out(trig_out)
  );

  AST_APPLY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((apply_q != '0) && !(wr_hit && cfg_addr == AW'(A_APPLY))) |=> (apply_q == '0)); // R9
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int unsigned PORTS  = 4,
  parameter int unsigned CHAN_W = 4
) (
  input  logic [PORTS-1:0][CHAN_W-1:0] port_in,
  output logic [PORTS-1:0][CHAN_W-1:0] port_out
);
  logic [CHAN_W-1:0] bus;

  always_comb begin
    bus = '0;
    for (int p = 0; p < PORTS; p++) bus = bus | port_in[p];
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign port_out[p] = bus;
  end
endmodule

// File: rtl/xtrig_fabric.sv
module xtrig_fabric
  import xtrig_pkg::*;
#(
  parameter int unsigned N_UNIT = UNIT_N,
  parameter int unsigned TW     = TRIG_W,
  parameter int unsigned CW     = CHAN_W,
  parameter int unsigned AW     = ADDR_W,
  localparam int unsigned SEL_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1,
  localparam int unsigned ALL_W = N_UNIT * TW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [SEL_W-1:0] cfg_unit,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [TW-1:0]    cfg_data,
  input  logic [ALL_W-1:0] trig_in,
  output logic [ALL_W-1:0] trig_in_ack,
  output logic [ALL_W-1:0] trig_out,
  input  logic [ALL_W-1:0] trig_out_ack
);
  logic [N_UNIT-1:0][CW-1:0] to_mx;
  logic [N_UNIT-1:0][CW-1:0] from_mx;

  assign cfg_ready = 1'b1;

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    xtrig_unit #(
      .UNIT_ID(u), .SEL_W(SEL_W), .TW(TW), .CW(CW), .AW(AW)
    ) unit_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_valid   (cfg_valid),
      .cfg_unit    (cfg_unit),
      .cfg_addr    (cfg_addr),
      .cfg_data    (cfg_data),
      .trig_in     (trig_in[u*TW +: TW]),
      .trig_in_ack (trig_in_ack[u*TW +: TW]),
      .trig_out    (trig_out[u*TW +: TW]),
      .trig_out_ack(trig_out_ack[u*TW +: TW]),
      .chan_to_mx  (to_mx[u]),
      .chan_from_mx(from_mx[u])
    );
  end

  xtrig_matrix #(.PORTS(N_UNIT), .CHAN_W(CW)) mx_i (
    .port_in (to_mx),
    .port_out(from_mx)
  );
endmodule

// File: tb/xtrig_fabric_tb.sv
`timescale 1ns/1ps
module xtrig_fabric_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [1:0]  cfg_unit = '0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic [31:0] trig_in = '0;
  logic [31:0] trig_in_ack;
  logic [31:0] trig_out;
  logic [31:0] trig_out_ack = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] m_in  [4][4];
  logic [7:0] m_out [4][4];
  logic       m_en  [4];

  always #4 clk = ~clk;

  xtrig_fabric dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_unit(cfg_unit), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .trig_in(trig_in), .trig_in_ack(trig_in_ack),
    .trig_out(trig_out), .trig_out_ack(trig_out_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_exp(input logic [31:0] v, input int au, input logic [3:0] am);
    logic [3:0] ch = '0;
    logic [31:0] r = '0;
    for (int u = 0; u < 4; u++)
      for (int c = 0; c < 4; c++)
        if ((v[u*8 +: 8] & m_in[u][c]) != 0) ch[c] = 1'b1;
    if (au >= 0) ch = ch | am;
    for (int u = 0; u < 4; u++)
      for (int o = 0; o < 8; o++)
        for (int c = 0; c < 4; c++)
          if (m_en[u] && ch[c] && m_out[u][c][o]) r[u*8+o] = 1'b1;
    return r;
  endfunction

  task automatic cfg_wr(input int u, input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_unit = 2'(u); cfg_addr = 4'(a); cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (a == 0) m_en[u] = d[0];
    else if (a >= 4 && a < 8) m_in[u][a-4] = d;
    else if (a >= 8 && a < 12) m_out[u][a-8] = d;
  endtask

  task automatic clear_outs();
    @(negedge clk); trig_out_ack = '1;
    @(negedge clk); trig_out_ack = '0;
    chk("R7 drop after ack", trig_out, 32'h0);
  endtask

  task automatic trial(input logic [31:0] v, input string tag);
    logic [31:0] e;
    e = f_exp(v, -1, 4'h0);
    @(negedge clk); trig_in = v;
    @(negedge clk); trig_in = '0;
    chk("R4 input ack", trig_in_ack, v);
    @(negedge clk);
    chk(tag, trig_out, e);
    @(negedge clk);
    chk("R7 hold without ack", trig_out, e);
    clear_outs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    int a;
    void'($urandom(32'h5eed));
    for (int u = 0; u < 4; u++) begin
      m_en[u] = 1'b0;
      for (int c = 0; c < 4; c++) begin m_in[u][c] = '0; m_out[u][c] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs at reset", trig_out, 32'h0);
    chk("R1 input ack at reset", trig_in_ack, 32'h0);
    chk("R2 ready high", {31'h0, cfg_ready}, 32'h1);
    trial(32'hFFFF_FFFF, "R1 masks cleared");

    // one-to-many inside a unit and across the matrix on channel 3
    cfg_wr(0, 0, 8'h01); cfg_wr(2, 0, 8'h01);
    cfg_wr(0, 7, 8'h01);
    cfg_wr(0, 11, 8'h81); cfg_wr(2, 11, 8'h04);
    trial(32'h0000_0001, "R5 one-to-many");
    chk("R6 cross unit", trig_out, 32'h0);
    e = f_exp(32'h1, -1, 4'h0);
    chk("R6 expected map", e, 32'h0004_0081);
    // many-to-one: unit3 input 6 also on channel 3
    cfg_wr(3, 7, 8'h40);
    trial(32'h4000_0000, "R5 many-to-one");
    trial(32'h4000_0001, "R5 many-to-one both");
    // unused addresses
    cfg_wr(0, 1, 8'hFF); cfg_wr(0, 13, 8'hFF); cfg_wr(2, 3, 8'h00); cfg_wr(2, 15, 8'h00);
    @(negedge clk);
    chk("R10 no fire on unused write", trig_out, 32'h0);
    trial(32'h0000_0001, "R10 routing unchanged");
    // enable off
    cfg_wr(2, 0, 8'h00);
    trial(32'h0000_0001, "R8 disabled unit silent");
    cfg_wr(2, 0, 8'h01); cfg_wr(0, 0, 8'h00);
    trial(32'h0000_0001, "R8 disabled unit still drives channels");
    cfg_wr(0, 0, 8'h01);
    // apply strobe
    e = f_exp(32'h0, 1, 4'h8);
    cfg_wr(1, 12, 8'h08);
    @(negedge clk);
    chk("R9 apply strobe fires", trig_out, e);
    clear_outs();
    @(negedge clk);
    chk("R9 apply is one-shot", trig_out, 32'h0);
    // held-high input
    @(negedge clk); trig_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 first event", trig_out, 32'h0004_0081);
    clear_outs();
    repeat (5) @(negedge clk);
    chk("R3 held input no refire", trig_out, 32'h0);
    trig_in = '0;
    // new event in the ack cycle wins
    @(negedge clk); trig_out_ack = '1; trig_in = 32'h1;
    @(negedge clk); trig_in = '0;
    @(negedge clk);
    chk("R7 set beats ack", trig_out, 32'h0004_0081);
    @(negedge clk);
    chk("R7 then drops", trig_out, 32'h0);
    trig_out_ack = '0;

    // constrained random
    for (int t = 0; t < 300; t++) begin
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        a = int'($urandom_range(0, 15));
        if (a == 12) a = 13;
        cfg_wr(int'($urandom_range(0, 3)), a,
               (a == 0) ? 8'($urandom_range(0, 3) != 0) : 8'($urandom));
      end
      v = $urandom & $urandom & $urandom;
      trial(v, "R5 R6 random routing");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule